// File: doc/BRIEF.md
# Programmable Reloading Interrupt Timer

This block is a periodic down-counter behind a small register port. Software programs a 28-bit period, enables the counter, and each time the period runs out the block raises a sticky pending flag and reloads the count, so that it fires again and again for as long as it stays enabled. While the flag is pending and interrupts are enabled, exactly one interrupt line is driven. That line belongs to one of four cores and is either the core's normal or its fast interrupt input, chosen by a 3-bit steering register.

Three 32-bit registers make up the software view. A steering register sits at offset 0x24. A control/status word at 0x34 carries the pending flag, the restart bit, the interrupt enable, the counter enable and the period. A write-only acknowledge word at 0x38 clears the flag and can restart the count. The counter is a two-state machine. In state CNT_IDLE it holds still. In state CNT_RUN it decrements once per clock. The named transitions are: start (CNT_IDLE or CNT_RUN to CNT_RUN, loading the period when the period is non-zero), zero-start (to CNT_IDLE when the period is zero), stop (to CNT_IDLE when the control word is written with the enable clear), and wrap (CNT_RUN to CNT_RUN when the count reaches one: it reloads the period and signals expiry). The bus is single-cycle: writes take effect at the clock edge, and reads are combinational from the current address.

Top module: `reload_irq_timer`

## Requirements
- R1: After reset the steering register and the control word both read 0, the counter is idle and no interrupt line is driven.
- R2: A write to offset 0x24 keeps only bits 2:0, and a read of 0x24 returns those bits zero-extended.
- R3: The control word at 0x34 reads back the last value written to it in full, as long as no expiry or acknowledge has changed the flag: bit 31 pending flag, bit 30 restart, bit 29 interrupt enable, bit 28 counter enable, bits 27:0 period.
- R4: A control write with bit 28 set and a period V other than zero sets the flag exactly V clock edges after the write edge, and again every V edges after that while the counter stays enabled.
- R5: A control write with bit 28 clear stops the counter, and after it no expiry sets the flag.
- R6: A write to offset 0x38 with bit 31 set clears the flag, and a read of 0x38 always returns 0.
- R7: A write to 0x38 with bit 30 set reloads the count from the period when bit 28 of the control word is set, so the next flag comes V edges after that write. When bit 28 is clear, the write has no effect on the counter.
- R8: An interrupt line is driven only while bit 29 and the flag are both set. The line is the fast one of core route[1:0] when route bit 2 is 1, and the normal one of that core when route bit 2 is 0.
- R9: Enabling with a period of 0 leaves the counter idle and never sets the flag.
- R10: When an acknowledge clears the flag in the same cycle as an expiry, the expiry wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_core | output | 4 | Normal interrupt line, one per core |
| fiq_core | output | 4 | Fast interrupt line, one per core |

## Verification
The assertions assume that a write drives a single, stable address for the whole cycle. They also assume that the start and stop requests to the counter never arrive together, which holds because a control write produces exactly one of the two. The stimulus changes the bus only on falling edges, issues one access per cycle and never sends a control write and an acknowledge in the same cycle. The expiry-against-acknowledge collision is placed on its exact edge by counting cycles from the enabling write.

// File: rtl/prit_pkg.sv
package prit_pkg;
    localparam int          VAL_W      = 28;
    localparam int          REG_W      = 32;
    localparam logic [7:0]  OFS_ROUTE  = 8'h24;
    localparam logic [7:0]  OFS_CTRL   = 8'h34;
    localparam logic [7:0]  OFS_ACK    = 8'h38;
    localparam int          BIT_FLAG   = 31;
    localparam int          BIT_RSTRT  = 30;
    localparam int          BIT_IE     = 29;
    localparam int          BIT_EN     = 28;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/prit_counter.sv
module prit_counter
    import prit_pkg::*;
#(
    parameter int CW = VAL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [CW-1:0] reload_val,
    output logic          expire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    cnt_state_e    state_q, state_d;
    logic [CW-1:0] count_q, count_d;

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            CNT_IDLE: ;
            CNT_RUN: begin
                if (count_q == ONE) count_d = reload_val;
                else                count_d = count_q - ONE;
            end
        endcase
        if (stop) begin
            state_d = CNT_IDLE;
        end else if (start) begin
            if (reload_val != '0) begin
                state_d = CNT_RUN;
                count_d = reload_val;
            end else begin
                state_d = CNT_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        expire = (state_q == CNT_RUN) && (count_q == ONE);
    end

    // R9
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN) |-> (count_q != '0));
    // R9
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop && reload_val == '0) |=> (state_q == CNT_IDLE));
    // R5
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state_q == CNT_IDLE));
endmodule

// File: rtl/prit_regs.sv
module prit_regs
    import prit_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             expire,
    output logic [REG_W-1:0] bus_rdata,
    output logic [RW-1:0]    route_q,
    output logic             int_en,
    output logic             flag_q,
    output logic             start,
    output logic             stop,
    output logic [VAL_W-1:0] reload_val
);
    logic [BIT_FLAG-1:0] ctrl_q;
    logic route_wr, ctrl_wr, ack_wr;

    always_comb begin
        route_wr   = bus_sel && bus_we && (bus_addr == OFS_ROUTE);
        ctrl_wr    = bus_sel && bus_we && (bus_addr == OFS_CTRL);
        ack_wr     = bus_sel && bus_we && (bus_addr == OFS_ACK);
        start      = (ctrl_wr && bus_wdata[BIT_EN])
                   || (ack_wr && bus_wdata[BIT_RSTRT] && ctrl_q[BIT_EN]);
        stop       = ctrl_wr && !bus_wdata[BIT_EN];
        reload_val = ctrl_wr ? bus_wdata[VAL_W-1:0] : ctrl_q[VAL_W-1:0];
        int_en     = ctrl_q[BIT_IE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '0;
            ctrl_q  <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (route_wr) route_q <= bus_wdata[RW-1:0];
            if (ctrl_wr)  ctrl_q  <= bus_wdata[BIT_FLAG-1:0];
            if (expire)
                flag_q <= 1'b1;
            else if (ctrl_wr)
                flag_q <= bus_wdata[BIT_FLAG];
            else if (ack_wr && bus_wdata[BIT_FLAG])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_ROUTE)
            bus_rdata = {{(REG_W-RW){1'b0}}, route_q};
        else if (bus_addr == OFS_CTRL)
            bus_rdata = {flag_q, ctrl_q};
    end

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && bus_wdata[BIT_FLAG] && !expire) |=> !flag_q);
    // R10
    expire_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);
endmodule

// File: rtl/prit_route.sv
module prit_route #(
    parameter int NCORE = 4,
    parameter int CW    = $clog2(NCORE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_en,
    input  logic             flag,
    input  logic [CW:0]      route_sel,
    output logic [NCORE-1:0] irq_core,
    output logic [NCORE-1:0] fiq_core
);
    logic active;
    assign active = int_en && flag;

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        assign irq_core[i] = active && !route_sel[CW]
                           && (route_sel[CW-1:0] == CW'(i));
        assign fiq_core[i] = active &&  route_sel[CW]
                           && (route_sel[CW-1:0] == CW'(i));
    end

    // R8
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && flag) |-> ($countones({fiq_core, irq_core}) == 1));
    // R8
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_en && flag) |-> ({fiq_core, irq_core} == '0));
endmodule

// File: rtl/reload_irq_timer.sv
module reload_irq_timer
    import prit_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic [NCORE-1:0] irq_core,
    output logic [NCORE-1:0] fiq_core
);
    localparam int CORE_W  = $clog2(NCORE);
    localparam int ROUTE_W = CORE_W + 1;

    logic [ROUTE_W-1:0] route_q;
    logic               int_en, flag_q, start, stop, expire;
    logic [VAL_W-1:0]   reload_val;

    prit_regs #(.RW(ROUTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .expire(expire), .bus_rdata(bus_rdata),
        .route_q(route_q), .int_en(int_en), .flag_q(flag_q),
        .start(start), .stop(stop), .reload_val(reload_val)
    );

    prit_counter #(.CW(VAL_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .reload_val(reload_val), .expire(expire)
    );

    prit_route #(.NCORE(NCORE), .CW(CORE_W)) u_route (
        .clk(clk), .rst_n(rst_n), .int_en(int_en), .flag(flag_q),
        .route_sel(route_q), .irq_core(irq_core), .fiq_core(fiq_core)
    );
endmodule

// File: tb/reload_irq_timer_test.sv
module reload_irq_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_core, fiq_core;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    reload_irq_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_core(irq_core), .fiq_core(fiq_core)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // {write value, expected {fiq,irq}} with interrupt enable and flag set
    localparam logic [39:0] RT_VEC [8] = '{
        {32'h0000_0000, 8'h01}, {32'h0000_0001, 8'h02},
        {32'h0000_0002, 8'h04}, {32'h0000_0003, 8'h08},
        {32'h0000_0004, 8'h10}, {32'h0000_0005, 8'h20},
        {32'hFFFF_FFFE, 8'h40}, {32'h0000_000F, 8'h80}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic flag_is(input string req, input logic exp);
        logic [31:0] d;
        rd(8'h34, d);
        check(req, {31'b0, d[31]}, {31'b0, exp});
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h24, d); check("R1 route", d, 32'h0);
        rd(8'h34, d); check("R1 ctrl", d, 32'h0);
        check("R1 lines", {24'b0, fiq_core, irq_core}, 32'h0);

        // R2 / R8 steering table, flag and enable forced by control write
        wr(8'h34, 32'hA000_0000);
        for (int i = 0; i < 8; i++) begin
            wr(8'h24, RT_VEC[i][39:8]);
            rd(8'h24, d);
            check("R2 route readback", d, {29'b0, RT_VEC[i][10:8]});
            check("R8 steering", {24'b0, fiq_core, irq_core},
                  {24'b0, RT_VEC[i][7:0]});
        end
        wr(8'h24, 32'h0);

        // R3 / R4 period 5, normal line of core 0
        wr(8'h34, 32'h3000_0005);
        rd(8'h34, d); check("R3 ctrl readback", d, 32'h3000_0005);
        repeat (4) @(negedge clk);
        flag_is("R4 before expiry", 1'b0);
        @(negedge clk);
        flag_is("R4 at expiry", 1'b1);
        check("R8 irq core0", {24'b0, fiq_core, irq_core}, 32'h1);
        // R6 acknowledge, then R4 periodic refire
        wr(8'h38, 32'h8000_0000);
        flag_is("R6 ack clears", 1'b0);
        rd(8'h38, d); check("R6 ack reads zero", d, 32'h0);
        repeat (3) @(negedge clk);
        flag_is("R4 before second expiry", 1'b0);
        @(negedge clk);
        flag_is("R4 second expiry", 1'b1);

        // R8 flag without interrupt enable drives nothing
        wr(8'h34, 32'h8000_0000);
        flag_is("R8 flag held", 1'b1);
        check("R8 disabled lines", {24'b0, fiq_core, irq_core}, 32'h0);

        // R5 stopped counter never expires
        wr(8'h34, 32'h2000_0003);
        repeat (20) @(negedge clk);
        flag_is("R5 stopped", 1'b0);

        // R9 zero period stays idle
        wr(8'h34, 32'h3000_0000);
        repeat (20) @(negedge clk);
        flag_is("R9 zero period", 1'b0);

        // R7 restart through acknowledge while enabled
        wr(8'h34, 32'h3000_0006);
        repeat (4) @(negedge clk);
        wr(8'h38, 32'h4000_0000);
        repeat (5) @(negedge clk);
        flag_is("R7 restarted not yet", 1'b0);
        @(negedge clk);
        flag_is("R7 restarted expiry", 1'b1);
        // R7 restart ignored while disabled
        wr(8'h34, 32'h2000_0006);
        wr(8'h38, 32'h4000_0000);
        repeat (20) @(negedge clk);
        flag_is("R7 disabled restart ignored", 1'b0);

        // R10 acknowledge lands on the expiry edge
        wr(8'h34, 32'h3000_0003);
        repeat (2) @(negedge clk);
        wr(8'h38, 32'h8000_0000);
        flag_is("R10 expiry wins", 1'b1);
        wr(8'h38, 32'h8000_0000);
        flag_is("R10 later ack clears", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule